// File: doc/BRIEF.md
# Transaction-Counting Frame Marker

This block drives a single framing output that marks groups of bus transactions for an external peripheral. It watches the read and write strobes produced by a bus sequencer. A clock is counted as one transaction when at least one strobe is high. Clocks in which neither strobe is high leave the count alone. The frame length therefore follows bus activity, not elapsed time.

There are two output shapes, picked by a mode bit. In pulse shape the output goes high for one clock after each completed group of transactions. In level shape the output inverts after each completed group, so a full period spans two groups. In level shape the output keeps its value through any number of idle clocks.

The group length is set by a 4-bit length field, where a field value of `n` means `n+1` transactions. An enable input clears the count and forces the output low. With two-cycle transfers, only the strobed address phase is counted.

Top module: `frame_gen`

## Requirements
- R1: A clock counts as one transaction when `rd_strb` or `wr_strb` is high. A clock with both strobes low does not advance the count and does not complete a group.
- R2: A clock with both `rd_strb` and `wr_strb` high counts as exactly one transaction.
- R3: With `shape` = 0 (pulse), `frame` is high in the clock after the transaction that completes a group of `len`+1 transactions. It is low in every other clock.
- R4: In pulse shape, `len` = 0 makes `frame` high after every transaction. `len` = 1 makes it high after every second transaction.
- R5: With `shape` = 1 (level), `frame` inverts in the clock after every (`len`+1)-th transaction, giving a period of 2·(`len`+1) transactions.
- R6: In level shape, `frame` keeps its value through any number of clocks without a transaction.
- R7: While `enable` is low, the count returns to zero and `frame` is low in the following clock. This takes precedence over a group completing in the same clock.
- R8: While `rst_n` is low, `frame` is low and the count is zero. Release is synchronised to `clk` over two clocks.
- R9: Changing `shape` while enabled keeps the count. The next group completes on the same transaction as it would have without the change.
- R10: A transaction completes the group when the count already reached is at least `len`. Lowering `len` in the middle of a group therefore ends that group at the next transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enables framing; low clears count and output |
| shape | input | 1 | 0 = one-clock pulse, 1 = inverting level |
| len | input | 4 | Group length minus one, in transactions |
| rd_strb | input | 1 | Read strobe from the sequencer |
| wr_strb | input | 1 | Write strobe from the sequencer |
| frame | output | 1 | Frame marker |

## Verification
Two events can fall in the same clock: a transaction that completes a group, and the clock in which `enable` falls. The bench provokes this by dropping `enable` exactly on the completing strobe, in both shapes. The expected result is a low `frame` and a fresh count. A second collision is a `shape` or `len` change landing on a strobe clock. A behavioural reference model, built on integers, is compared with `frame` on every clock to judge it.

// File: rtl/frame_gen_pkg.sv
package frame_gen_pkg;
  typedef enum logic {
    SHAPE_PULSE = 1'b0,
    SHAPE_LEVEL = 1'b1
  } shape_e;
endpackage

// File: rtl/frame_rst_sync.sv
module frame_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/frame_txn_counter.sv
module frame_txn_counter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             txn,
  input  logic [LEN_W-1:0] limit,
  output logic             wrap
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  // group completes when the count already reached meets the limit (R10)
  assign wrap   = txn && (cnt_q >= limit);
  assign cnt_en = clear || txn;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (txn)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frame_shaper.sv
module frame_shaper
  import frame_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  shape_e shape,
  input  logic   wrap,
  output logic   frame
);
  logic frame_q;
  logic frame_d;

  always_comb begin
    frame_d = frame_q;
    if (!enable) begin
      frame_d = 1'b0;
    end else begin
      unique case (shape)
        SHAPE_PULSE: frame_d = wrap;
        SHAPE_LEVEL: frame_d = wrap ? ~frame_q : frame_q;
        default:     frame_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= 1'b0;
    else        frame_q <= frame_d;
  end

  assign frame = frame_q;
endmodule

// File: rtl/frame_gen.sv
module frame_gen
  import frame_gen_pkg::*;
#(
  parameter int LEN_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             shape,
  input  logic [LEN_W-1:0] len,
  input  logic             rd_strb,
  input  logic             wr_strb,
  output logic             frame
);
  logic   rst_n_int;
  logic   txn;
  logic   wrap;
  shape_e shape_sel;

  // one transaction per strobed clock, whichever strobes are high (R1, R2)
  assign txn       = rd_strb | wr_strb;
  assign shape_sel = shape_e'(shape);

  frame_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  frame_txn_counter #(.LEN_W(LEN_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n_int),
    .clear (!enable),
    .txn   (txn),
    .limit (len),
    .wrap  (wrap)
  );

  frame_shaper u_shaper (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .enable (enable),
    .shape  (shape_sel),
    .wrap   (wrap),
    .frame  (frame)
  );
endmodule

// File: rtl/frame_gen_checker.sv
module frame_gen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic shape,
  input logic rd_strb,
  input logic wr_strb,
  input logic frame
);
  logic txn;
  assign txn = rd_strb | wr_strb;

  // R3: a pulse only follows an enabled transaction
  p_pulse_needs_txn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!shape && $past(!shape) && frame) |-> $past(txn && enable));

  // R1: an enabled idle clock in pulse shape leaves the output low
  p_idle_no_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && !shape && !txn) |-> !frame);

  // R6: level shape holds through idle clocks
  p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && shape && !txn) |-> $stable(frame));

  // R7: disable forces the output low next clock
  p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> !frame);
endmodule

bind frame_gen frame_gen_checker u_frame_gen_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .shape   (shape),
  .rd_strb (rd_strb),
  .wr_strb (wr_strb),
  .frame   (frame)
);

// File: tb/frame_gen_bench.sv
module frame_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       shape;
  logic [3:0] len;
  logic       rd_strb;
  logic       wr_strb;
  logic       frame;

  int checks;
  int fails;
  int m_cnt;
  bit m_frame;
  bit done;

  frame_gen u_frame_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .shape(shape), .len(len),
    .rd_strb(rd_strb), .wr_strb(wr_strb), .frame(frame)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt   = 0;
      m_frame = 0;
    end else if (!enable) begin
      m_cnt   = 0;
      m_frame = 0;
    end else if (rd_strb || wr_strb) begin
      if (m_cnt >= int'(len)) begin
        m_cnt   = 0;
        m_frame = shape ? !m_frame : 1'b1;
      end else begin
        m_cnt = m_cnt + 1;
        if (!shape) m_frame = 0;
      end
    end else if (!shape) begin
      m_frame = 0;
    end
  end

  task automatic check(input string tag, input bit exp);
    checks++;
    if (frame !== exp) begin
      fails++;
      $display("FAIL %s: frame=%b expected=%b at %0t", tag, frame, exp, $time);
    end
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic step(input bit rd, input bit wr, input string tag);
    rd_strb = rd;
    wr_strb = wr;
    @(posedge clk);
    @(negedge clk);
    check(tag, m_frame);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: expired, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    rst_n = 0; enable = 0; shape = 0; len = 4'd0; rd_strb = 0; wr_strb = 0;
    repeat (3) @(negedge clk);
    check("R8", 1'b0);
    rst_n = 1;
    idle(4, "R8");
    enable = 1;

    // R4: len 0 pulses after every transaction, len 1 every second
    shape = 0; len = 4'd0;
    step(1, 0, "R4"); step(0, 1, "R4"); step(0, 0, "R4");
    len = 4'd1;
    for (int i = 0; i < 6; i++) step(1, 0, "R4");
    // R3: len 3, strobes sparse (two-cycle phases: strobe then idle)
    len = 4'd3;
    for (int i = 0; i < 8; i++) begin
      step(i[0], !i[0], "R3");
      step(0, 0, "R1");
    end
    // R2: both strobes together count once
    len = 4'd2;
    for (int i = 0; i < 6; i++) step(1, 1, "R2");

    // R5/R6: level shape
    enable = 0; step(0, 0, "R7"); enable = 1;
    shape = 1; len = 4'd1;
    for (int i = 0; i < 8; i++) step(1, 0, "R5");
    step(1, 0, "R5");
    idle(7, "R6");
    step(0, 1, "R5");
    idle(5, "R6");
    len = 4'd15;
    for (int i = 0; i < 34; i++) step(i % 3 == 0, i % 5 == 0, "R5");

    // R7: disable on the completing transaction, both shapes
    len = 4'd2; enable = 0; step(0, 0, "R7"); enable = 1;
    step(1, 0, "R7"); step(1, 0, "R7");
    enable = 0; step(1, 0, "R7");
    enable = 1;
    step(1, 0, "R7"); step(1, 0, "R7"); step(1, 0, "R7");
    shape = 0;
    step(1, 0, "R7"); step(1, 0, "R7");
    enable = 0; step(0, 1, "R7"); step(0, 1, "R7");
    enable = 1;

    // R9: shape change mid-group keeps the count
    len = 4'd3;
    step(1, 0, "R9"); step(1, 0, "R9");
    shape = 1; step(1, 0, "R9"); step(1, 0, "R9");
    shape = 0; step(1, 0, "R9"); step(1, 0, "R9"); step(0, 0, "R9");

    // R10: lowering len mid-group ends it at the next transaction
    len = 4'd7;
    for (int i = 0; i < 5; i++) step(1, 0, "R10");
    len = 4'd2; step(0, 1, "R10"); step(0, 1, "R10"); step(0, 1, "R10");

    // R8: reset in mid-run clears output
    shape = 1; len = 4'd0;
    step(1, 0, "R8");
    rst_n = 0;
    #1;
    check("R8", 1'b0);
    @(negedge clk);
    rst_n = 1;
    idle(3, "R8");
    step(1, 0, "R8"); step(1, 0, "R8");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule